// File: doc/BRIEF.md
# Trap Entry State Saver

This block performs the architectural bookkeeping that happens when a processor thread takes a trap. A request arrives with a 9-bit trap type, a flag that says whether the handler runs hyperprivileged, and a flag that selects the error-recovery (RED) entry flavour. The block latches a snapshot of the live control state (trap level, global level, condition codes, address-space identifier, processor and hypervisor state words, current window, spare-window count, PC and NPC). From that snapshot it computes every value that must be written on trap entry.

It produces the trap-stack entry for the new trap level and the updated live registers. The trap-stack entry holds the packed trap-state word, the saved PC and NPC, the saved hypervisor state and the trap type. The updated live registers are trap level, global level, processor state, hypervisor state and window pointer. All of these values appear together in the single cycle that follows the request. During that cycle a done pulse and one write strobe per register are raised, so that an external register file can commit the entry atomically. Vector addresses, trap arbitration and the storage itself are handled elsewhere.

Top module: `trap_entry_saver`

## Requirements
- R1: After reset, `done` and every write strobe are 0 and every result output is 0.
- R2: A request (`reqValid` high while `done` is low) at a rising edge makes `done` and all write strobes, except `cwpWe`, high for exactly the following cycle. A request seen while `done` is high is ignored: `done` drops, no strobe rises and every result output keeps its value.
- R3: `trapLevelOut` equals the current trap level plus one, held at `MAX_TL` when already there. It is both the new trap level and the trap-stack index for the entry.
- R4: `tstateOut` is zero except for these fields: global level in bits 42:40, condition codes in 39:32, address-space identifier in 31:24, processor state in 20:8 and window pointer in 4:0.
- R5: `tpcOut`/`tnpcOut` are PC/NPC with bits 63:32 cleared when processor-state bit 3 (address mask) is 1, and unmodified otherwise.
- R6: `htstateOut` is the current hypervisor state word, and `ttOut` is the request's trap type.
- R7: `glOut` is the global level plus one, limited to `MAX_GL` for hyperprivileged or RED entry and to `MAX_PGL` for privileged entry.
- R8: For trap types 0x080–0x0BF, `cwpOut` = (cwp + spare + 2) mod `NWINDOWS`. For 0x0C0–0x0FF it is (cwp − 1) mod `NWINDOWS`, and for 0x024 it is (cwp + 1) mod `NWINDOWS`. `cwpWe` pulses with `done` only for these types; for all others `cwpOut` equals cwp.
- R9: On every entry, processor-state bit 4 (FP enable) is set and bits 3 (address mask) and 1 (interrupt enable) are cleared. On privileged entry, bit 2 (privileged) is also set and bit 9 takes bit 8's value. On hyperprivileged entry, bit 2 is unchanged.
- R10: Hyperprivileged entry sets hypervisor-state bit 2 (hyperprivileged) and clears bits 5 (RED) and 10 (instruction-break enable), leaving bit 0 and the rest unchanged. Privileged entry leaves the hypervisor state word unchanged.
- R11: RED entry uses the `MAX_GL` limit whatever `reqToHyper` is. It sets processor-state bit 2 and hypervisor-state bits 5 and 2, and clears hypervisor bit 10. Trap level, trap-stack and window updates follow R3–R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Trap request |
| reqTrapType | input | 9 | Trap type |
| reqToHyper | input | 1 | Handler runs hyperprivileged |
| reqRedMode | input | 1 | RED-flavour entry |
| curTl | input | TL_W | Current trap level |
| curGl | input | 3 | Current global level |
| curCcr | input | 8 | Condition codes |
| curAsi | input | 8 | Address-space identifier |
| curPstate | input | 13 | Processor state word |
| curHpstate | input | 12 | Hypervisor state word |
| curCwp | input | CWP_W | Current window pointer |
| curCansave | input | CWP_W | Spare-window count |
| curPc | input | PC_W | Current PC |
| curNpc | input | PC_W | Next PC |
| done | output | 1 | Entry complete pulse |
| trapLevelOut | output | TL_W | New trap level / stack index |
| tlWe | output | 1 | Trap level write strobe |
| tstateOut | output | 64 | Packed trap-state word |
| tstateWe | output | 1 | Trap-state write strobe |
| tpcOut | output | PC_W | Saved PC |
| tpcWe | output | 1 | Saved PC write strobe |
| tnpcOut | output | PC_W | Saved NPC |
| tnpcWe | output | 1 | Saved NPC write strobe |
| htstateOut | output | 12 | Saved hypervisor state |
| htstateWe | output | 1 | Saved hypervisor state strobe |
| ttOut | output | 9 | Saved trap type |
| ttWe | output | 1 | Trap type write strobe |
| glOut | output | 3 | New global level |
| glWe | output | 1 | Global level write strobe |
| pstateOut | output | 13 | New processor state |
| pstateWe | output | 1 | Processor state write strobe |
| hpstateOut | output | 12 | New hypervisor state |
| hpstateWe | output | 1 | Hypervisor state write strobe |
| cwpOut | output | CWP_W | New window pointer |
| cwpWe | output | 1 | Window pointer write strobe |

## Verification
On every cycle the assertions enforce the following properties:
- the done pulse lasts one cycle, and an accepted request is answered in the next cycle;
- trap level and global level stay within their limits;
- the FP-enable bit is always set in the new processor state;
- hypervisor bit 0 and the trap type pass through intact;
- trap types outside the window-rotating ranges leave the window pointer untouched.

The bench scenarios are needed for the exact packing of the trap-state word and the address-mask truncation. They also cover the modular window arithmetic at both wrap points and the privilege-dependent global-level limits. Finally, they show that a request arriving during `done` changes no output.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int TT_W = 9;
  localparam int GL_W = 3;
  localparam int PS_W = 13;
  localparam int HP_W = 12;
  localparam int TS_W = 64;
  localparam int BYTE_W = 8;

  // processor state bit positions
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;

  // hypervisor state bit positions
  localparam int HP_TLZ   = 0;
  localparam int HP_HPRIV = 2;
  localparam int HP_RED   = 5;
  localparam int HP_IBE   = 10;

  // trap-state word field offsets
  localparam int TS_CWP_LSB = 0;
  localparam int TS_PS_LSB  = 8;
  localparam int TS_ASI_LSB = 24;
  localparam int TS_CCR_LSB = 32;
  localparam int TS_GL_LSB  = 40;

  // special trap type that advances the window by one
  localparam logic [TT_W-1:0] TT_CLEAN = 9'h024;

  typedef struct packed {
    logic load;    // capture snapshot this edge
    logic commit;  // results valid, strobes high
  } ctlStrobes_t;
endpackage

// File: rtl/trap_window_rotator.sv
module trap_window_rotator
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  localparam int CWP_W = $clog2(NWINDOWS)
) (
  input  logic [TT_W-1:0]  trapType,
  input  logic [CWP_W-1:0] cwpIn,
  input  logic [CWP_W-1:0] cansaveIn,
  output logic [CWP_W-1:0] cwpNext,
  output logic             rotate
);
  logic isSpill, isFill, isClean;
  int unsigned sum;

  assign isSpill = (trapType[TT_W-1:6] == 3'b010);
  assign isFill  = (trapType[TT_W-1:6] == 3'b011);
  assign isClean = (trapType == TT_CLEAN);

  always_comb begin
    sum = 32'(cwpIn);
    if (isSpill)      sum = 32'(cwpIn) + 32'(cansaveIn) + 32'd2;
    else if (isFill)  sum = 32'(cwpIn) + 32'(NWINDOWS) - 32'd1;
    else if (isClean) sum = 32'(cwpIn) + 32'd1;
    cwpNext = CWP_W'(sum % 32'(NWINDOWS));
  end

  assign rotate = isSpill | isFill | isClean;
endmodule

// File: rtl/trap_save_control.sv
module trap_save_control
  import trap_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctlStrobes_t ctl
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= reqValid && !doneQ;
  end

  assign ctl.load   = reqValid && !doneQ;
  assign ctl.commit = doneQ;
endmodule

// File: rtl/trap_save_datapath.sv
module trap_save_datapath
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int MAX_PGL = 2,
  parameter int PC_W = 64,
  localparam int CWP_W = $clog2(NWINDOWS),
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [TT_W-1:0]   reqTrapType,
  input  logic              reqToHyper,
  input  logic              reqRedMode,
  input  logic [TL_W-1:0]   curTl,
  input  logic [GL_W-1:0]   curGl,
  input  logic [BYTE_W-1:0] curCcr,
  input  logic [BYTE_W-1:0] curAsi,
  input  logic [PS_W-1:0]   curPstate,
  input  logic [HP_W-1:0]   curHpstate,
  input  logic [CWP_W-1:0]  curCwp,
  input  logic [CWP_W-1:0]  curCansave,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   curNpc,
  output logic [TL_W-1:0]   tlQ,
  output logic [TS_W-1:0]   tstateQ,
  output logic [PC_W-1:0]   tpcQ,
  output logic [PC_W-1:0]   tnpcQ,
  output logic [HP_W-1:0]   htstateQ,
  output logic [TT_W-1:0]   ttQ,
  output logic [GL_W-1:0]   glQ,
  output logic [PS_W-1:0]   pstateQ,
  output logic [HP_W-1:0]   hpstateQ,
  output logic [CWP_W-1:0]  cwpQ,
  output logic              cwpRotQ
);
  logic [TL_W-1:0]  tlNext;
  logic [GL_W:0]    glInc;
  logic [GL_W:0]    glLim;
  logic [GL_W-1:0]  glNext;
  logic [TS_W-1:0]  tstateNext;
  logic [PC_W-1:0]  pcMask;
  logic [PS_W-1:0]  pstateNext;
  logic [HP_W-1:0]  hpstateNext;
  logic [CWP_W-1:0] cwpNext;
  logic             cwpRot;

  // trap level with saturation
  assign tlNext = (curTl >= TL_W'(MAX_TL)) ? TL_W'(MAX_TL) : curTl + 1'b1;

  // global level with destination-dependent limit
  assign glInc  = {1'b0, curGl} + 1'b1;
  assign glLim  = (reqRedMode || reqToHyper) ? (GL_W+1)'(MAX_GL) : (GL_W+1)'(MAX_PGL);
  assign glNext = (glInc > glLim) ? glLim[GL_W-1:0] : glInc[GL_W-1:0];

  // packed trap-state word
  always_comb begin
    tstateNext = '0;
    tstateNext[TS_GL_LSB  +: GL_W]   = curGl;
    tstateNext[TS_CCR_LSB +: BYTE_W] = curCcr;
    tstateNext[TS_ASI_LSB +: BYTE_W] = curAsi;
    tstateNext[TS_PS_LSB  +: PS_W]   = curPstate;
    tstateNext[TS_CWP_LSB +: CWP_W]  = curCwp;
  end

  // narrow-address truncation of saved PCs
  assign pcMask = curPstate[PS_AM] ? {{(PC_W-32){1'b0}}, {32{1'b1}}} : {PC_W{1'b1}};

  // privilege state updates
  always_comb begin
    pstateNext  = curPstate;
    hpstateNext = curHpstate;
    pstateNext[PS_PEF] = 1'b1;
    pstateNext[PS_AM]  = 1'b0;
    pstateNext[PS_IE]  = 1'b0;
    if (reqRedMode) begin
      pstateNext[PS_PRIV]    = 1'b1;
      hpstateNext[HP_RED]    = 1'b1;
      hpstateNext[HP_HPRIV]  = 1'b1;
      hpstateNext[HP_IBE]    = 1'b0;
    end else if (reqToHyper) begin
      hpstateNext[HP_HPRIV]  = 1'b1;
      hpstateNext[HP_RED]    = 1'b0;
      hpstateNext[HP_IBE]    = 1'b0;
    end else begin
      pstateNext[PS_PRIV] = 1'b1;
      pstateNext[PS_CLE]  = curPstate[PS_TLE];
    end
  end

  trap_window_rotator #(.NWINDOWS(NWINDOWS)) uRot (
    .trapType (reqTrapType),
    .cwpIn    (curCwp),
    .cansaveIn(curCansave),
    .cwpNext  (cwpNext),
    .rotate   (cwpRot)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlQ      <= '0;
      tstateQ  <= '0;
      tpcQ     <= '0;
      tnpcQ    <= '0;
      htstateQ <= '0;
      ttQ      <= '0;
      glQ      <= '0;
      pstateQ  <= '0;
      hpstateQ <= '0;
      cwpQ     <= '0;
      cwpRotQ  <= 1'b0;
    end else if (ctl.load) begin
      tlQ      <= tlNext;
      tstateQ  <= tstateNext;
      tpcQ     <= curPc & pcMask;
      tnpcQ    <= curNpc & pcMask;
      htstateQ <= curHpstate;
      ttQ      <= reqTrapType;
      glQ      <= glNext;
      pstateQ  <= pstateNext;
      hpstateQ <= hpstateNext;
      cwpQ     <= cwpNext;
      cwpRotQ  <= cwpRot;
    end
  end
endmodule

// File: rtl/trap_entry_saver.sv
module trap_entry_saver
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int MAX_PGL = 2,
  parameter int PC_W = 64,
  localparam int CWP_W = $clog2(NWINDOWS),
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TT_W-1:0]   reqTrapType,
  input  logic              reqToHyper,
  input  logic              reqRedMode,
  input  logic [TL_W-1:0]   curTl,
  input  logic [GL_W-1:0]   curGl,
  input  logic [BYTE_W-1:0] curCcr,
  input  logic [BYTE_W-1:0] curAsi,
  input  logic [PS_W-1:0]   curPstate,
  input  logic [HP_W-1:0]   curHpstate,
  input  logic [CWP_W-1:0]  curCwp,
  input  logic [CWP_W-1:0]  curCansave,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   curNpc,
  output logic              done,
  output logic [TL_W-1:0]   trapLevelOut,
  output logic              tlWe,
  output logic [TS_W-1:0]   tstateOut,
  output logic              tstateWe,
  output logic [PC_W-1:0]   tpcOut,
  output logic              tpcWe,
  output logic [PC_W-1:0]   tnpcOut,
  output logic              tnpcWe,
  output logic [HP_W-1:0]   htstateOut,
  output logic              htstateWe,
  output logic [TT_W-1:0]   ttOut,
  output logic              ttWe,
  output logic [GL_W-1:0]   glOut,
  output logic              glWe,
  output logic [PS_W-1:0]   pstateOut,
  output logic              pstateWe,
  output logic [HP_W-1:0]   hpstateOut,
  output logic              hpstateWe,
  output logic [CWP_W-1:0]  cwpOut,
  output logic              cwpWe
);
  ctlStrobes_t ctl;
  logic cwpRotQ;

  trap_save_control uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .ctl     (ctl)
  );

  trap_save_datapath #(
    .NWINDOWS(NWINDOWS), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL),
    .MAX_PGL(MAX_PGL), .PC_W(PC_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqTrapType(reqTrapType),
    .reqToHyper (reqToHyper),
    .reqRedMode (reqRedMode),
    .curTl      (curTl),
    .curGl      (curGl),
    .curCcr     (curCcr),
    .curAsi     (curAsi),
    .curPstate  (curPstate),
    .curHpstate (curHpstate),
    .curCwp     (curCwp),
    .curCansave (curCansave),
    .curPc      (curPc),
    .curNpc     (curNpc),
    .tlQ        (trapLevelOut),
    .tstateQ    (tstateOut),
    .tpcQ       (tpcOut),
    .tnpcQ      (tnpcOut),
    .htstateQ   (htstateOut),
    .ttQ        (ttOut),
    .glQ        (glOut),
    .pstateQ    (pstateOut),
    .hpstateQ   (hpstateOut),
    .cwpQ       (cwpOut),
    .cwpRotQ    (cwpRotQ)
  );

  assign done      = ctl.commit;
  assign tlWe      = ctl.commit;
  assign tstateWe  = ctl.commit;
  assign tpcWe     = ctl.commit;
  assign tnpcWe    = ctl.commit;
  assign htstateWe = ctl.commit;
  assign ttWe      = ctl.commit;
  assign glWe      = ctl.commit;
  assign pstateWe  = ctl.commit;
  assign hpstateWe = ctl.commit;
  assign cwpWe     = ctl.commit & cwpRotQ;
endmodule

// File: rtl/trap_entry_saver_checker.sv
module trap_entry_saver_checker
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  localparam int CWP_W = $clog2(NWINDOWS),
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [TT_W-1:0]  reqTrapType,
  input logic [HP_W-1:0]  curHpstate,
  input logic [CWP_W-1:0] curCwp,
  input logic             done,
  input logic [TL_W-1:0]  trapLevelOut,
  input logic [GL_W-1:0]  glOut,
  input logic [PS_W-1:0]  pstateOut,
  input logic [HP_W-1:0]  hpstateOut,
  input logic [TT_W-1:0]  ttOut,
  input logic [CWP_W-1:0] cwpOut,
  input logic             cwpWe
);
  logic plainType;
  assign plainType = (reqTrapType[TT_W-1:7] != 2'b01) && (reqTrapType != TT_CLEAN);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !done) |=> done);
  a_r3_tl_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (trapLevelOut != '0) && (trapLevelOut <= TL_W'(MAX_TL)));
  a_r7_gl_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> glOut <= GL_W'(MAX_GL));
  a_r9_fp_on: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pstateOut[PS_PEF]);
  a_r10_tlz_kept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !done) |=> hpstateOut[HP_TLZ] == $past(curHpstate[HP_TLZ]));
  a_r6_tt_saved: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !done) |=> ttOut == $past(reqTrapType));
  a_r8_window_held: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !done && plainType) |=> !cwpWe && cwpOut == $past(curCwp));
endmodule

bind trap_entry_saver trap_entry_saver_checker #(
  .NWINDOWS(NWINDOWS), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTrapType(reqTrapType),
  .curHpstate(curHpstate), .curCwp(curCwp), .done(done),
  .trapLevelOut(trapLevelOut), .glOut(glOut), .pstateOut(pstateOut),
  .hpstateOut(hpstateOut), .ttOut(ttOut), .cwpOut(cwpOut), .cwpWe(cwpWe)
);

// File: tb/trap_entry_saver_test.sv
module trap_entry_saver_test;
  localparam int NW = 8;
  localparam int MTL = 6;
  localparam int MGL = 3;
  localparam int MPGL = 2;
  localparam int CW = $clog2(NW);
  localparam int TLW = $clog2(MTL + 1);

  logic clk = 0, rstN = 0, reqValid = 0, reqToHyper = 0, reqRedMode = 0;
  logic [8:0] reqTrapType = '0;
  logic [TLW-1:0] curTl = '0;
  logic [2:0] curGl = '0;
  logic [7:0] curCcr = '0, curAsi = '0;
  logic [12:0] curPstate = '0;
  logic [11:0] curHpstate = '0;
  logic [CW-1:0] curCwp = '0, curCansave = '0;
  logic [63:0] curPc = '0, curNpc = '0;
  logic done, tlWe, tstateWe, tpcWe, tnpcWe, htstateWe, ttWe, glWe, pstateWe, hpstateWe, cwpWe;
  logic [TLW-1:0] trapLevelOut;
  logic [63:0] tstateOut, tpcOut, tnpcOut;
  logic [11:0] htstateOut, hpstateOut;
  logic [8:0] ttOut;
  logic [2:0] glOut;
  logic [12:0] pstateOut;
  logic [CW-1:0] cwpOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trap_entry_saver uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTrapType(reqTrapType),
    .reqToHyper(reqToHyper), .reqRedMode(reqRedMode), .curTl(curTl), .curGl(curGl),
    .curCcr(curCcr), .curAsi(curAsi), .curPstate(curPstate), .curHpstate(curHpstate),
    .curCwp(curCwp), .curCansave(curCansave), .curPc(curPc), .curNpc(curNpc),
    .done(done), .trapLevelOut(trapLevelOut), .tlWe(tlWe), .tstateOut(tstateOut),
    .tstateWe(tstateWe), .tpcOut(tpcOut), .tpcWe(tpcWe), .tnpcOut(tnpcOut),
    .tnpcWe(tnpcWe), .htstateOut(htstateOut), .htstateWe(htstateWe), .ttOut(ttOut),
    .ttWe(ttWe), .glOut(glOut), .glWe(glWe), .pstateOut(pstateOut), .pstateWe(pstateWe),
    .hpstateOut(hpstateOut), .hpstateWe(hpstateWe), .cwpOut(cwpOut), .cwpWe(cwpWe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // ---- reference model from the requirements ----
  function automatic logic [63:0] mTl(input logic [63:0] tl);
    return (tl >= MTL) ? 64'(MTL) : tl + 1;
  endfunction
  function automatic logic [63:0] mGl(input logic [63:0] gl, input bit hyp, input bit red);
    logic [63:0] lim = (hyp || red) ? 64'(MGL) : 64'(MPGL);
    return (gl + 1 > lim) ? lim : gl + 1;
  endfunction
  function automatic logic [63:0] mCwp(input logic [8:0] tt, input int cwp, input int cs);
    if (tt >= 9'h080 && tt <= 9'h0BF) return 64'((cwp + cs + 2) % NW);
    if (tt >= 9'h0C0 && tt <= 9'h0FF) return 64'((cwp + NW - 1) % NW);
    if (tt == 9'h024) return 64'((cwp + 1) % NW);
    return 64'(cwp);
  endfunction
  function automatic bit mRot(input logic [8:0] tt);
    return (tt >= 9'h080 && tt <= 9'h0FF) || tt == 9'h024;
  endfunction
  function automatic logic [63:0] mPs(input logic [12:0] p, input bit hyp, input bit red);
    logic [12:0] r = p;
    r[4] = 1; r[3] = 0; r[1] = 0;
    if (red) r[2] = 1;
    else if (!hyp) begin r[2] = 1; r[9] = p[8]; end
    return 64'(r);
  endfunction
  function automatic logic [63:0] mHp(input logic [11:0] h, input bit hyp, input bit red);
    logic [11:0] r = h;
    if (red) begin r[5] = 1; r[2] = 1; r[10] = 0; end
    else if (hyp) begin r[2] = 1; r[5] = 0; r[10] = 0; end
    return 64'(r);
  endfunction
  function automatic logic [63:0] mTs(input logic [2:0] gl, input logic [7:0] ccr,
                                      input logic [7:0] asi, input logic [12:0] ps, input logic [CW-1:0] cwp);
    logic [63:0] r = '0;
    r[42:40] = gl; r[39:32] = ccr; r[31:24] = asi; r[20:8] = ps; r[4:0] = 5'(cwp);
    return r;
  endfunction

  // Drive one request, check results in the done cycle.
  task automatic runTrap(input logic [8:0] tt, input bit hyp, input bit red, input int tl,
                         input int gl, input logic [12:0] ps, input logic [11:0] hp,
                         input int cwp, input int cs, input logic [63:0] pc, input logic [63:0] npc);
    logic [63:0] msk;
    @(negedge clk);
    reqTrapType = tt; reqToHyper = hyp; reqRedMode = red;
    curTl = TLW'(tl); curGl = 3'(gl); curCcr = 8'($urandom); curAsi = 8'($urandom);
    curPstate = ps; curHpstate = hp; curCwp = CW'(cwp); curCansave = CW'(cs);
    curPc = pc; curNpc = npc; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    msk = ps[3] ? 64'h0000_0000_FFFF_FFFF : '1;
    chk(done && tlWe && tstateWe && tpcWe && tnpcWe && htstateWe && ttWe && glWe && pstateWe && hpstateWe,
        "R2 strobes", {54'b0, done, tlWe, tstateWe, tpcWe, tnpcWe, htstateWe, ttWe, glWe, pstateWe, hpstateWe}, 64'h3FF);
    chk(64'(trapLevelOut) == mTl(64'(tl)), "R3 tl", 64'(trapLevelOut), mTl(64'(tl)));
    chk(tstateOut == mTs(curGl, curCcr, curAsi, ps, CW'(cwp)), "R4 tstate", tstateOut, mTs(curGl, curCcr, curAsi, ps, CW'(cwp)));
    chk(tpcOut == (pc & msk) && tnpcOut == (npc & msk), "R5 tpc/tnpc", tpcOut ^ tnpcOut, (pc & msk) ^ (npc & msk));
    chk(htstateOut == hp && ttOut == tt, "R6 htstate/tt", {40'b0, htstateOut, 3'b0, ttOut}, {40'b0, hp, 3'b0, tt});
    chk(64'(glOut) == mGl(64'(gl), hyp, red), red ? "R11 gl red" : "R7 gl", 64'(glOut), mGl(64'(gl), hyp, red));
    chk(64'(cwpOut) == mCwp(tt, cwp, cs) && cwpWe == mRot(tt), "R8 cwp", {63'(cwpOut), cwpWe},
        {63'(mCwp(tt, cwp, cs)), mRot(tt)});
    chk(64'(pstateOut) == mPs(ps, hyp, red), red ? "R11 pstate" : "R9 pstate", 64'(pstateOut), mPs(ps, hyp, red));
    chk(64'(hpstateOut) == mHp(hp, hyp, red), red ? "R11 hpstate" : "R10 hpstate", 64'(hpstateOut), mHp(hp, hyp, red));
  endtask

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    finishRun();
  end

  initial begin
    logic [63:0] heldTs;
    logic [TLW-1:0] heldTl;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!done && !tlWe && !cwpWe && !pstateWe, "R1 strobes", {60'b0, done, tlWe, cwpWe, pstateWe}, 64'd0);
    chk(tstateOut == 0 && tpcOut == 0 && trapLevelOut == 0 && glOut == 0 && cwpOut == 0, "R1 outputs", tstateOut, 64'd0);
    rstN = 1;

    // directed corners
    runTrap(9'h0BF, 0, 0, 0, 0, 13'h0100, 12'h401, 6, 7, 64'hDEAD_BEEF_1234_5678, 64'hDEAD_BEEF_1234_567C); // R8 spill wrap
    runTrap(9'h0C0, 1, 0, 2, 3, 13'h0008, 12'h021, 0, 0, 64'hFFFF_0000_8000_0000, 64'hFFFF_0000_8000_0004); // R8 fill wrap, R7 hyper sat, R5 mask
    runTrap(9'h024, 0, 0, MTL, 2, 13'h1FFF, 12'h000, NW - 1, 3, 64'h1, 64'h5);   // R8 clean wrap, R3 sat, R7 priv sat
    runTrap(9'h030, 0, 0, 1, 3, 13'h0000, 12'hFFF, 3, 1, 64'h10, 64'h14);         // R7 priv clamp, R8 no rotate
    runTrap(9'h100, 1, 0, 4, 1, 13'h0104, 12'h425, 5, 2, '1, '1);                 // R10 hyper entry
    runTrap(9'h005, 0, 1, MTL - 1, 2, 13'h0000, 12'h400, 2, 0, 64'h20, 64'h24);   // R11 red with priv flag
    runTrap(9'h080, 1, 1, 0, 3, 13'h0018, 12'h001, 7, 6, 64'h8000_0000_0000_0000, 64'h4); // R11 red + spill

    // R2 ignore while busy
    @(negedge clk);
    reqTrapType = 9'h0C5; reqToHyper = 0; reqRedMode = 0; curTl = 3'(2); curGl = 3'(1);
    curCwp = 3; reqValid = 1;
    @(negedge clk);
    heldTs = tstateOut; heldTl = trapLevelOut;
    curTl = 3'(4); curGl = 3'(0); curCwp = 6; reqTrapType = 9'h024;
    @(negedge clk);
    reqValid = 0;
    chk(!done && !tlWe && !cwpWe, "R2 ignore strobes", {61'b0, done, tlWe, cwpWe}, 64'd0);
    chk(tstateOut == heldTs && trapLevelOut == heldTl && ttOut == 9'h0C5 && cwpOut == 2,
        "R2 ignore hold", {tstateOut[59:0], 1'b0, trapLevelOut}, {heldTs[59:0], 1'b0, heldTl});

    // constrained random
    for (int i = 0; i < 200; i++) begin
      logic [8:0] tt;
      case ($urandom % 4)
        0: tt = 9'h080 + 9'($urandom % 64);
        1: tt = 9'h0C0 + 9'($urandom % 64);
        2: tt = 9'h024;
        default: tt = 9'($urandom);
      endcase
      runTrap(tt, 1'($urandom), ($urandom % 6) == 0, int'($urandom % (MTL + 1)),
              int'($urandom % (MGL + 1)), 13'($urandom), 12'($urandom),
              int'($urandom % NW), int'($urandom % (NW - 1)),
              {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule